// File: doc/BRIEF.md
# Folded 64-Point Radix-4 Inverse FFT Engine

This block computes a 64-point inverse FFT on complex fixed-point samples using one shared radix-4 butterfly. A whole frame of 64 samples arrives in a single valid/ready transfer and is copied into an internal 64-entry state register. The engine then walks through three stages of sixteen butterfly passes. In each pass it reads four neighbouring entries, multiplies them by twiddle factors, combines them in a radix-4 butterfly and writes the four results back. After the last pass of each stage, the whole register is reordered by a stride-by-4 permutation.

When the third stage is complete, the 64 results are offered on a valid/ready output. They stay there until the consumer takes them, and only then is a new frame accepted. Only one frame is in flight at a time. The transform size is fixed.

Every sample is packed into 32 bits. The real part is in bits [15:0] and the imaginary part in bits [31:16], both signed 16-bit two's complement. Entry e of a frame occupies bits [32e+31:32e] of the frame bus.

Top module: `ifft64_fold`

## Requirements
- R1: After reset `in_ready`=1 and `out_valid`=0. `in_ready` is 1 only while the engine is idle, never while it is computing or holding a result.
- R2: A frame is taken on a clock edge where `in_valid` and `in_ready` are both 1. Any `in_valid` or `in_data` activity while the engine is busy has no effect on the result.
- R3: `out_valid` becomes 1 exactly 48 clock edges after the accepting edge: 3 stages of 16 passes, one pass per cycle, with the stage counting 0 to 2 and the pass index q counting 0 to 15.
- R4: A pass forms m_k = x_k·t_k for k = 0..3, then y0=m0+m2, y1=m0−m2, y2=m1+m3, y3=i·(m1−m3), and then z0=y0+y2, z1=y1+y3, z2=y0−y2, z3=y1−y3. Every addition and subtraction saturates to the 16-bit signed range.
- R5: Each twiddle is t_k = exp(+j·2π·e/64) with e = (k·q·4^s) mod 64, where s is the stage and q the pass index. Both parts are rounded to Q1.14. A product is rounded by adding 2^13, shifted right arithmetically by 14, and saturated to 16 bits.
- R6: Pass q reads entries 4q..4q+3 as x0..x3, writes z0..z3 back to the same entries, and leaves every other entry unchanged.
- R7: After pass 15 of every stage, including the last, the register is permuted so that new entry j equals old entry (j mod 16)·4 + (j div 16). The results of pass 15 are written before the permutation is applied.
- R8: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_data` hold. An edge with `out_ready`=1 returns the engine to idle (`in_ready`=1, `out_valid`=0).
- R9: Full-scale inputs saturate rather than wrap around.
- R10: Multiplication by i swaps the parts and negates the new real part. Negating −32768 gives +32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input frame is offered |
| in_ready | output | 1 | Engine is idle and can take a frame |
| in_data | input | 2048 | 64 packed complex input samples |
| out_valid | output | 1 | Result frame is offered |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 2048 | 64 packed complex result samples |

## Verification
The assertions check the following on every cycle:
- the handshake states, including that `in_ready` is never high alongside a result or a pass;
- the pass sequencing and the 48-cycle schedule;
- that entries outside the active quad stay untouched during a pass;
- that the result holds while the consumer stalls.

Only the bench's scenarios can show that the numbers are right. It compares every output against its own floating-point-derived twiddles and its own model of the butterfly, the rounding, the saturation and the permutation. The frames it uses are:
- random frames;
- an impulse frame;
- full-scale positive and negative frames;
- frames during which garbage is driven on the input while the engine is busy.

// File: rtl/ifft_fold_pkg.sv
package ifft_fold_pkg;
  localparam int DW      = 16;
  localparam int NPTS    = 64;
  localparam int RADIX   = 4;
  localparam int NQUAD   = NPTS / RADIX;
  localparam int NSTG    = 3;
  localparam int QW      = $clog2(NQUAD);
  localparam int SW      = $clog2(NSTG);
  localparam int EW      = $clog2(NPTS);
  localparam int KW      = $clog2(RADIX);
  localparam int CW      = 2 * DW;
  localparam int FW      = NPTS * CW;
  localparam int TFRAC   = 14;
  localparam int PW      = 2 * DW + 2;

  typedef logic signed [DW-1:0] smp_t;
  typedef struct packed {
    smp_t im;
    smp_t re;
  } cplx_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} fsm_t;

  localparam logic signed [PW-1:0] PMAX = PW'((1 << (DW - 1)) - 1);
  localparam logic signed [PW-1:0] PMIN = -PMAX - PW'(1);
  localparam logic signed [PW-1:0] PRND = PW'(1 << (TFRAC - 1));

  function automatic smp_t sat_w(input logic signed [PW-1:0] v);
    if (v > PMAX) return PMAX[DW-1:0];
    if (v < PMIN) return PMIN[DW-1:0];
    return v[DW-1:0];
  endfunction

  function automatic cplx_t c_add(input cplx_t a, input cplx_t b);
    cplx_t r;
    r.re = sat_w(PW'(a.re) + PW'(b.re));
    r.im = sat_w(PW'(a.im) + PW'(b.im));
    return r;
  endfunction

  function automatic cplx_t c_sub(input cplx_t a, input cplx_t b);
    cplx_t r;
    r.re = sat_w(PW'(a.re) - PW'(b.re));
    r.im = sat_w(PW'(a.im) - PW'(b.im));
    return r;
  endfunction

  // (a + jb) * j = -b + ja, no multiplier
  function automatic cplx_t c_rot(input cplx_t a);
    cplx_t r;
    r.re = sat_w(-PW'(a.im));
    r.im = a.re;
    return r;
  endfunction

  function automatic cplx_t c_mul(input cplx_t x, input cplx_t t);
    logic signed [PW-1:0] pr, pi;
    cplx_t r;
    pr = PW'(x.re) * PW'(t.re) - PW'(x.im) * PW'(t.im);
    pi = PW'(x.re) * PW'(t.im) + PW'(x.im) * PW'(t.re);
    r.re = sat_w((pr + PRND) >>> TFRAC);
    r.im = sat_w((pi + PRND) >>> TFRAC);
    return r;
  endfunction

  // quarter-wave cosine in Q1.14, step 2*pi/64
  function automatic smp_t qcos(input logic [QW:0] r);
    case (r)
      5'd0:  return 16'sd16384;
      5'd1:  return 16'sd16305;
      5'd2:  return 16'sd16069;
      5'd3:  return 16'sd15679;
      5'd4:  return 16'sd15137;
      5'd5:  return 16'sd14449;
      5'd6:  return 16'sd13623;
      5'd7:  return 16'sd12665;
      5'd8:  return 16'sd11585;
      5'd9:  return 16'sd10394;
      5'd10: return 16'sd9102;
      5'd11: return 16'sd7723;
      5'd12: return 16'sd6270;
      5'd13: return 16'sd4756;
      5'd14: return 16'sd3196;
      5'd15: return 16'sd1606;
      default: return 16'sd0;
    endcase
  endfunction

  function automatic smp_t full_cos(input logic [EW-1:0] e);
    logic [QW:0] r, rr;
    r  = {1'b0, e[EW-3:0]};
    rr = (QW+1)'(NQUAD) - r;
    case (e[EW-1 -: 2])
      2'd0:    return qcos(r);
      2'd1:    return -qcos(rr);
      2'd2:    return -qcos(r);
      default: return qcos(rr);
    endcase
  endfunction

  function automatic cplx_t twiddle(input logic [EW-1:0] e);
    cplx_t t;
    t.re = full_cos(e);
    t.im = full_cos(e - EW'(NQUAD));  // sin(x) = cos(x - pi/2)
    return t;
  endfunction
endpackage

// File: rtl/ifft_fold_twiddle.sv
module ifft_fold_twiddle
  import ifft_fold_pkg::*;
(
  input  logic [SW-1:0] stage,
  input  logic [QW-1:0] quad,
  output cplx_t         tw [RADIX]
);
  for (genvar k = 0; k < RADIX; k++) begin : g_tw
    logic [EW-1:0] ex;
    assign ex    = EW'((k * int'(quad)) << (2 * int'(stage)));
    assign tw[k] = twiddle(ex);
  end
endmodule

// File: rtl/ifft_fold_bfly4.sv
module ifft_fold_bfly4
  import ifft_fold_pkg::*;
(
  input  cplx_t x  [RADIX],
  input  cplx_t tw [RADIX],
  output cplx_t z  [RADIX]
);
  cplx_t m [RADIX];
  cplx_t y [RADIX];

  always_comb begin
    for (int k = 0; k < RADIX; k++) m[k] = c_mul(x[k], tw[k]);
    y[0] = c_add(m[0], m[2]);
    y[1] = c_sub(m[0], m[2]);
    y[2] = c_add(m[1], m[3]);
    y[3] = c_rot(c_sub(m[1], m[3]));
    z[0] = c_add(y[0], y[2]);
    z[1] = c_add(y[1], y[3]);
    z[2] = c_sub(y[0], y[2]);
    z[3] = c_sub(y[1], y[3]);
  end
endmodule

// File: rtl/ifft_fold_ctrl.sv
module ifft_fold_ctrl
  import ifft_fold_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          out_valid,
  output logic [SW-1:0] stage,
  output logic [QW-1:0] quad,
  output logic          load_ev,
  output logic          step_ev,
  output logic          perm_ev,
  output logic          last_ev
);
  fsm_t st_q;

  assign in_ready  = (st_q == ST_IDLE);
  assign out_valid = (st_q == ST_DONE);
  assign load_ev   = in_ready && in_valid;
  assign step_ev   = (st_q == ST_RUN);
  assign perm_ev   = step_ev && (quad == QW'(NQUAD - 1));
  assign last_ev   = perm_ev && (stage == SW'(NSTG - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      stage <= '0;
      quad  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (in_valid) begin
          st_q  <= ST_RUN;
          stage <= '0;
          quad  <= '0;
        end
        ST_RUN: begin
          quad <= quad + QW'(1);
          if (perm_ev) begin
            if (last_ev) st_q <= ST_DONE;
            else         stage <= stage + SW'(1);
          end
        end
        ST_DONE: if (out_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_ready_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!out_valid && !step_ev));
  p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (step_ev && stage == '0 && quad == '0));
  p_quad_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && !last_ev) |=> (step_ev && quad == $past(quad) + QW'(1)));
  p_stage_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |-> (stage <= SW'(NSTG - 1)));
  p_finish_r3: assert property (@(posedge clk) disable iff (!rst_n)
    last_ev |=> out_valid);
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid));
endmodule

// File: rtl/ifft64_fold.sv
module ifft64_fold
  import ifft_fold_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [FW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [FW-1:0] out_data
);
  logic [SW-1:0] stage;
  logic [QW-1:0] quad;
  logic load_ev, step_ev, perm_ev, last_ev;

  cplx_t st_q [NPTS];
  cplx_t in_c [NPTS];
  cplx_t wr   [NPTS];
  cplx_t pm   [NPTS];
  cplx_t nx   [NPTS];
  cplx_t x    [RADIX];
  cplx_t tw   [RADIX];
  cplx_t z    [RADIX];

  ifft_fold_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .stage(stage), .quad(quad),
    .load_ev(load_ev), .step_ev(step_ev), .perm_ev(perm_ev), .last_ev(last_ev)
  );

  ifft_fold_twiddle u_tw (.stage(stage), .quad(quad), .tw(tw));
  ifft_fold_bfly4   u_bf (.x(x), .tw(tw), .z(z));

  for (genvar e = 0; e < NPTS; e++) begin : g_io
    assign in_c[e]              = cplx_t'(in_data[e*CW +: CW]);
    assign out_data[e*CW +: CW] = st_q[e];
  end

  // 16-way read muxes, write demuxes, permutation and load select
  always_comb begin
    for (int k = 0; k < RADIX; k++) x[k] = st_q[{quad, KW'(k)}];
    for (int e = 0; e < NPTS; e++) wr[e] = st_q[e];
    if (step_ev)
      for (int k = 0; k < RADIX; k++) wr[{quad, KW'(k)}] = z[k];
    for (int j = 0; j < NPTS; j++)
      pm[j] = wr[(j % NQUAD) * RADIX + (j / NQUAD)];
    for (int e = 0; e < NPTS; e++)
      nx[e] = load_ev ? in_c[e] : (perm_ev ? pm[e] : wr[e]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < NPTS; e++) st_q[e] <= '0;
    end else begin
      for (int e = 0; e < NPTS; e++) st_q[e] <= nx[e];
    end
  end

  for (genvar e = 0; e < NPTS; e++) begin : g_keep
    p_untouched_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_ev && !perm_ev && quad != QW'(e / RADIX)) |=> $stable(st_q[e]));
  end

  p_hold_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !load_ev) |=> $stable(out_data) || !out_valid);
endmodule

// File: tb/ifft64_fold_tb.sv
module ifft64_fold_tb_top;
  localparam int N = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [N*32-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [N*32-1:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  int ire [N], iim [N];
  int mre [N], mim [N];

  always #10 clk = ~clk;  // 50 MHz

  ifft64_fold dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int bsat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int rnd_r(input real v);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  function automatic int tw_re(input int e);
    return rnd_r(16384.0 * $cos(2.0 * 3.141592653589793 * e / 64.0));
  endfunction

  function automatic int tw_im(input int e);
    return rnd_r(16384.0 * $sin(2.0 * 3.141592653589793 * e / 64.0));
  endfunction

  function automatic int q14(input longint p);
    return bsat((p + 8192) >>> 14);
  endfunction

  // reference transform on ire/iim into mre/mim
  task automatic run_model();
    int ar [4], ai [4], yr [4], yi [4], dr, di;
    int tr [N], ti [N];
    for (int e = 0; e < N; e++) begin mre[e] = ire[e]; mim[e] = iim[e]; end
    for (int s = 0; s < 3; s++) begin
      for (int q = 0; q < 16; q++) begin
        for (int k = 0; k < 4; k++) begin
          int ex, wr_, wi_, a, b;
          ex  = (k * q * (1 << (2 * s))) % 64;
          wr_ = tw_re(ex); wi_ = tw_im(ex);
          a = mre[4*q+k]; b = mim[4*q+k];
          ar[k] = q14(longint'(a) * wr_ - longint'(b) * wi_);
          ai[k] = q14(longint'(a) * wi_ + longint'(b) * wr_);
        end
        yr[0] = bsat(ar[0] + ar[2]); yi[0] = bsat(ai[0] + ai[2]);
        yr[1] = bsat(ar[0] - ar[2]); yi[1] = bsat(ai[0] - ai[2]);
        yr[2] = bsat(ar[1] + ar[3]); yi[2] = bsat(ai[1] + ai[3]);
        dr = bsat(ar[1] - ar[3]);    di = bsat(ai[1] - ai[3]);
        yr[3] = bsat(-di);           yi[3] = dr;
        mre[4*q+0] = bsat(yr[0] + yr[2]); mim[4*q+0] = bsat(yi[0] + yi[2]);
        mre[4*q+1] = bsat(yr[1] + yr[3]); mim[4*q+1] = bsat(yi[1] + yi[3]);
        mre[4*q+2] = bsat(yr[0] - yr[2]); mim[4*q+2] = bsat(yi[0] - yi[2]);
        mre[4*q+3] = bsat(yr[1] - yr[3]); mim[4*q+3] = bsat(yi[1] - yi[3]);
      end
      for (int j = 0; j < N; j++) begin
        tr[j] = mre[(j % 16) * 4 + j / 16];
        ti[j] = mim[(j % 16) * 4 + j / 16];
      end
      for (int j = 0; j < N; j++) begin mre[j] = tr[j]; mim[j] = ti[j]; end
    end
  endtask

  function automatic logic [N*32-1:0] pack_in();
    logic [N*32-1:0] v;
    for (int e = 0; e < N; e++) begin
      v[e*32 +: 16]      = 16'(ire[e]);
      v[e*32 + 16 +: 16] = 16'(iim[e]);
    end
    return v;
  endfunction

  // one frame: send, wait, compare, stall, release
  task automatic do_frame(input string tag, input bit junk);
    int cyc, bad, fr, fa, fe;
    bit busy_rdy;
    logic [N*32-1:0] snap;
    run_model();
    @(negedge clk);
    in_data  = pack_in();
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = junk;
    cyc = 0; busy_rdy = 1'b0;
    while (!out_valid && cyc < 200) begin
      if (junk) in_data = {N{$urandom()}};
      if (in_ready) busy_rdy = 1'b1;
      @(posedge clk); cyc++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    check(cyc == 48, "R3", {tag, " latency"}, cyc, 48);
    check(!busy_rdy, "R1", {tag, " in_ready while busy"}, busy_rdy, 0);
    bad = 0; fr = -1; fa = 0; fe = 0;
    for (int e = 0; e < N; e++) begin
      int ar_, ai_;
      ar_ = int'($signed(out_data[e*32 +: 16]));
      ai_ = int'($signed(out_data[e*32 + 16 +: 16]));
      if (ar_ != mre[e] || ai_ != mim[e]) begin
        bad++;
        if (fr < 0) begin fr = e; fa = (ar_ != mre[e]) ? ar_ : ai_;
          fe = (ar_ != mre[e]) ? mre[e] : mim[e]; end
      end
    end
    check(bad == 0, junk ? "R2/R4/R5/R6/R7" : "R4/R5/R6/R7/R9/R10",
          {tag, " result word"}, fa, fe);
    snap = out_data;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid && out_data == snap, "R8", {tag, " hold under stall"},
          out_valid, 1);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    check(in_ready && !out_valid, "R8", {tag, " release to idle"},
          {in_ready, out_valid}, 2);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready && !out_valid, "R1", "reset state", {in_ready, out_valid}, 2);
    rst_n = 1'b1;

    for (int e = 0; e < N; e++) begin ire[e] = 0; iim[e] = 0; end
    do_frame("zero", 1'b0);

    for (int e = 0; e < N; e++) begin ire[e] = (e == 0) ? 8000 : 0; iim[e] = 0; end
    do_frame("impulse", 1'b0);

    for (int e = 0; e < N; e++) begin ire[e] = 32767; iim[e] = 32767; end
    do_frame("full positive R9", 1'b0);

    for (int e = 0; e < N; e++) begin ire[e] = -32768; iim[e] = -32768; end
    do_frame("full negative R10", 1'b0);

    for (int n = 0; n < 4; n++) begin
      for (int e = 0; e < N; e++) begin
        ire[e] = int'($urandom_range(0, 2047)) - 1024;
        iim[e] = int'($urandom_range(0, 2047)) - 1024;
      end
      do_frame("random small", 1'b0);
    end

    for (int n = 0; n < 2; n++) begin
      for (int e = 0; e < N; e++) begin
        ire[e] = int'($urandom_range(0, 65535)) - 32768;
        iim[e] = int'($urandom_range(0, 65535)) - 32768;
      end
      do_frame("random full", 1'b0);
    end

    for (int n = 0; n < 2; n++) begin
      for (int e = 0; e < N; e++) begin
        ire[e] = int'($urandom_range(0, 4095)) - 2048;
        iim[e] = int'($urandom_range(0, 4095)) - 2048;
      end
      do_frame("busy junk R2", 1'b1);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule